// File: doc/BRIEF.md
# Probabilistic Address-Event Fan-Out Mapper

This block sits on an address-event link between a sender and a receiver, both using the four-phase request/acknowledge handshake. Each incoming event carries a source address. The block uses that address to select a row of an on-chip mapping table. It then produces between zero and eight outgoing events, each with its own destination address, in the order the slots are stored in the row. The incoming event is acknowledged only after the last outgoing event has finished or been skipped. Upstream traffic therefore waits for the whole fan-out of an event.

A two-bit mode input chooses how a row is used. One mode performs a plain address translation. A second expands the event into the row's full list of slots. A third gives each slot an 8-bit emission probability, and an internal 16-bit linear feedback shift register decides whether that slot's event goes out. A row with a count of zero drops the input event. The table is filled through a single-cycle write port. That port is honoured only while no event is being processed. All inputs are assumed to be synchronous to `clk`.

Top module: `aerProbMapper`

## Requirements
- R1: After reset, `outReq` and `inAck` are low, `outAddr` is zero, every row count is zero, and the random register holds 16'hACE1.
- R2: The mapper raises `inAck` only after every output event of the current input has completed or been skipped. `inAck` is never high together with `outReq`. It stays high while `inReq` is high, and it falls once `inReq` is low.
- R3: The mapper holds `outReq` high, with `outAddr` stable, until `outAck` is seen high. It then lowers `outReq` and does not raise it again until `outAck` is low.
- R4: In mode 0 (translation), a row whose count is at least 1 yields exactly one output carrying the address in slot 0. A row with count 0 yields no output.
- R5: In mode 1 (and mode 3), a row with count N yields the addresses of slots 0 to N-1, in slot order. A count of 0 drops the event, and a count above 8 is treated as 8.
- R6: In mode 2, each candidate slot 0 to min(N,8)-1 is tested in order. A slot is emitted when its probability is 255, or when bits 7:0 of the random register are below its probability. The register steps once per tested candidate, and only in mode 2. One step turns r into {r[14:0], r[15]^r[13]^r[12]^r[10]}.
- R7: A `wrEn` pulse with `wrIsCount`=1 loads `wrCount` into the count of row `wrRow`. With `wrIsCount`=0 it loads `wrAddr` and `wrProb` into slot `wrSlot` of row `wrRow`. A pulse is ignored while an event is in progress, that is, from the accepting edge until `inAck` has fallen.
- R8: Mode and input address are captured when an event is accepted. Changes to them during the event have no effect on that event.
- R9: No input event produces more than 8 output events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeIn | input | 2 | 0 translate, 1 and 3 fan-out, 2 probabilistic |
| inReq | input | 1 | Input event request |
| inAddr | input | IN_W | Input event address (table row) |
| inAck | output | 1 | Input event acknowledge |
| outReq | output | 1 | Output event request |
| outAddr | output | OUT_W | Output event address |
| outAck | input | 1 | Output event acknowledge |
| wrEn | input | 1 | Table write strobe |
| wrIsCount | input | 1 | 1 writes a row count, 0 writes a slot |
| wrRow | input | IN_W | Row being written |
| wrSlot | input | 3 | Slot being written |
| wrCount | input | 4 | Count value |
| wrAddr | input | OUT_W | Slot output address |
| wrProb | input | 8 | Slot probability threshold |

## Verification
A corrupted slot index or row register shows up at the ports as a missing, extra or reordered output address in the very next handshake of the affected event. A random register that steps when it should not, or fails to step when it should, breaks the emission pattern of the next probabilistic event. The bench therefore mixes probabilistic events with fan-out events and catches the divergence within one or two events. A control state that mis-sequences shows up on the first clock where `outReq` and `inAck` overlap, or where `outReq` is high while `inReq` is low.

// File: rtl/aerMapPkg.sv
package aerMapPkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_MANY = 2'd1,
    MODE_PROB = 2'd2,
    MODE_ALT  = 2'd3
  } mapMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_REQ,
    ST_REL,
    ST_ACK
  } mapState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchIn;
    logic draw;
    logic loadOut;
    logic incIdx;
    logic wrOk;
  } mapCtl_t;

  localparam logic [7:0] PROB_ALWAYS = 8'hFF;

endpackage

// File: rtl/aerMapDatapath.sv
module aerMapDatapath
  import aerMapPkg::*;
#(
  parameter int IN_W      = 6,
  parameter int OUT_W     = 8,
  parameter int FAN       = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mapCtl_t                     ctl,
  input  logic [IN_W-1:0]             inAddr,
  input  logic [1:0]                  modeIn,
  input  logic                        wrEn,
  input  logic                        wrIsCount,
  input  logic [IN_W-1:0]             wrRow,
  input  logic [$clog2(FAN)-1:0]      wrSlot,
  input  logic [$clog2(FAN+1)-1:0]    wrCount,
  input  logic [OUT_W-1:0]            wrAddr,
  input  logic [7:0]                  wrProb,
  output logic [OUT_W-1:0]            outAddr,
  output logic                        atEnd,
  output logic                        drawHit
);

  localparam int ROWS    = 1 << IN_W;
  localparam int SLOT_W  = $clog2(FAN);
  localparam int CNT_W   = $clog2(FAN+1);
  localparam int ENTRIES = ROWS * FAN;
  localparam logic [CNT_W-1:0] FAN_C = CNT_W'(FAN);

  logic [CNT_W-1:0] countMem [ROWS];
  logic [OUT_W-1:0] addrMem  [ENTRIES];
  logic [7:0]       probMem  [ENTRIES];

  logic [IN_W-1:0]  rowReg;
  mapMode_e         modeReg;
  logic [CNT_W-1:0] idxReg;
  logic [15:0]      lfsr;

  logic             doWrite;
  logic [SLOT_W-1:0] curSlot;
  logic [CNT_W-1:0] rowCnt;
  logic [CNT_W-1:0] clampCnt;
  logic [CNT_W-1:0] limit;
  logic [7:0]       curProb;
  logic             lfsrFb;

  assign doWrite = ctl.wrOk && wrEn;
  assign curSlot = idxReg[SLOT_W-1:0];

  // row counts are reset so that an unloaded row drops its events
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) countMem[i] <= '0;
    end else if (doWrite && wrIsCount) begin
      countMem[wrRow] <= wrCount;
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite && !wrIsCount) begin
      addrMem[{wrRow, wrSlot}] <= wrAddr;
      probMem[{wrRow, wrSlot}] <= wrProb;
    end
  end

  assign lfsrFb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg  <= '0;
      modeReg <= MODE_ONE;
      idxReg  <= '0;
      lfsr    <= LFSR_SEED;
      outAddr <= '0;
    end else begin
      if (ctl.latchIn) begin
        rowReg  <= inAddr;
        modeReg <= mapMode_e'(modeIn);
        idxReg  <= '0;
      end else if (ctl.incIdx) begin
        idxReg <= idxReg + 1'b1;
      end
      if (ctl.draw && modeReg == MODE_PROB) lfsr <= {lfsr[14:0], lfsrFb};
      if (ctl.loadOut) outAddr <= addrMem[{rowReg, curSlot}];
    end
  end

  assign rowCnt   = countMem[rowReg];
  assign clampCnt = (rowCnt > FAN_C) ? FAN_C : rowCnt;

  always_comb begin
    if (modeReg == MODE_ONE) limit = (rowCnt != '0) ? CNT_W'(1) : '0;
    else                     limit = clampCnt;
  end

  assign atEnd   = idxReg >= limit;
  assign curProb = probMem[{rowReg, curSlot}];
  assign drawHit = (modeReg != MODE_PROB) || (curProb == PROB_ALWAYS) ||
                   (lfsr[7:0] < curProb);

endmodule

// File: rtl/aerMapControl.sv
module aerMapControl
  import aerMapPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inReq,
  input  logic    outAck,
  input  logic    atEnd,
  input  logic    drawHit,
  output mapCtl_t ctl,
  output logic    outReq,
  output logic    inAck
);

  mapState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    ctl.wrOk  = (state == ST_IDLE);
    case (state)
      ST_IDLE: if (inReq) begin
        ctl.latchIn = 1'b1;
        nextState   = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (atEnd) begin
          nextState = ST_ACK;
        end else begin
          ctl.draw = 1'b1;
          if (drawHit) begin
            ctl.loadOut = 1'b1;
            nextState   = ST_REQ;
          end else begin
            ctl.incIdx = 1'b1;
          end
        end
      end
      ST_REQ: if (outAck) nextState = ST_REL;
      ST_REL: if (!outAck) begin
        ctl.incIdx = 1'b1;
        nextState  = ST_DECIDE;
      end
      ST_ACK: if (!inReq) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign outReq = (state == ST_REQ);
  assign inAck  = (state == ST_ACK);

endmodule

// File: rtl/aerProbMapper.sv
module aerProbMapper
  import aerMapPkg::*;
#(
  parameter int IN_W  = 6,
  parameter int OUT_W = 8,
  parameter int FAN   = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modeIn,
  input  logic                     inReq,
  input  logic [IN_W-1:0]          inAddr,
  output logic                     inAck,
  output logic                     outReq,
  output logic [OUT_W-1:0]         outAddr,
  input  logic                     outAck,
  input  logic                     wrEn,
  input  logic                     wrIsCount,
  input  logic [IN_W-1:0]          wrRow,
  input  logic [$clog2(FAN)-1:0]   wrSlot,
  input  logic [$clog2(FAN+1)-1:0] wrCount,
  input  logic [OUT_W-1:0]         wrAddr,
  input  logic [7:0]               wrProb
);

  mapCtl_t ctl;
  logic    atEnd;
  logic    drawHit;

  aerMapControl ctrl (
    .clk(clk), .rstN(rstN), .inReq(inReq), .outAck(outAck),
    .atEnd(atEnd), .drawHit(drawHit), .ctl(ctl),
    .outReq(outReq), .inAck(inAck)
  );

  aerMapDatapath #(
    .IN_W(IN_W), .OUT_W(OUT_W), .FAN(FAN), .LFSR_SEED(LFSR_SEED)
  ) dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inAddr(inAddr), .modeIn(modeIn),
    .wrEn(wrEn), .wrIsCount(wrIsCount), .wrRow(wrRow), .wrSlot(wrSlot),
    .wrCount(wrCount), .wrAddr(wrAddr), .wrProb(wrProb),
    .outAddr(outAddr), .atEnd(atEnd), .drawHit(drawHit)
  );

endmodule

// File: rtl/aerProbMapperChk.sv
module aerProbMapperChk #(
  parameter int FAN   = 8,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReq,
  input logic             inAck,
  input logic             outReq,
  input logic             outAck,
  input logic [OUT_W-1:0] outAddr
);

  logic       prevReq;
  logic [7:0] evCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq <= 1'b0;
      evCnt   <= '0;
    end else begin
      prevReq <= outReq;
      if (outReq && !prevReq) evCnt <= evCnt + 1'b1;
      else if (inAck)         evCnt <= '0;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReq && !outAck |=> outReq);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReq && $past(outReq) |-> $stable(outAddr));

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReq) |-> $past(outAck));

  // R2
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outReq && inAck));

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    inAck && inReq |=> inAck);

  // R2
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inAck) |-> $past(!inReq));

  // R9
  fanout_chk: assert property (@(posedge clk) disable iff (!rstN)
    evCnt <= 8'(FAN));

endmodule

bind aerProbMapper aerProbMapperChk #(.FAN(FAN), .OUT_W(OUT_W)) mapChk (
  .clk(clk), .rstN(rstN), .inReq(inReq), .inAck(inAck),
  .outReq(outReq), .outAck(outAck), .outAddr(outAddr)
);

// File: tb/aerProbMapper_test.sv
`timescale 1ns/1ps
module aerProbMapper_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeIn = 2'd0;
  logic       inReq = 1'b0;
  logic [5:0] inAddr = '0;
  logic       inAck;
  logic       outReq;
  logic [7:0] outAddr;
  logic       outAck = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrIsCount = 1'b0;
  logic [5:0] wrRow = '0;
  logic [2:0] wrSlot = '0;
  logic [3:0] wrCount = '0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrProb = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  int         cntM [64];
  logic [7:0] addrM [64][8];
  logic [7:0] probM [64][8];
  logic [15:0] lfsrM = 16'hACE1;
  logic [7:0] expQ [$];
  logic [7:0] gotQ [$];
  bit         eventOpen = 0;
  int         rxDelay = 0;

  always #4 clk = ~clk;

  aerProbMapper uut (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .inReq(inReq), .inAddr(inAddr),
    .inAck(inAck), .outReq(outReq), .outAddr(outAddr), .outAck(outAck),
    .wrEn(wrEn), .wrIsCount(wrIsCount), .wrRow(wrRow), .wrSlot(wrSlot),
    .wrCount(wrCount), .wrAddr(wrAddr), .wrProb(wrProb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // receiver: four-phase with a varying response delay
  initial begin
    forever begin
      @(negedge clk);
      if (outReq && !outAck) begin
        gotQ.push_back(outAddr);
        repeat (rxDelay) @(negedge clk);
        outAck = 1'b1;
        rxDelay = (rxDelay + 1) % 3;
      end else if (!outReq && outAck) begin
        repeat (rxDelay) @(negedge clk);
        outAck = 1'b0;
      end
    end
  end

  // per-clock protocol comparison (R2)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(!(outReq && inAck), "R2 req/ack overlap", int'(outReq), 0);
      if (!eventOpen) check(!outReq && !inAck, "R2 activity outside event", int'(outReq), 0);
    end
  end

  task automatic writeCount(input int row, input int n);
    @(negedge clk);
    wrEn = 1; wrIsCount = 1; wrRow = 6'(row); wrCount = 4'(n);
    @(negedge clk);
    wrEn = 0;
    cntM[row] = n;
  endtask

  task automatic writeSlot(input int row, input int slot, input logic [7:0] a, input logic [7:0] p);
    @(negedge clk);
    wrEn = 1; wrIsCount = 0; wrRow = 6'(row); wrSlot = 3'(slot); wrAddr = a; wrProb = p;
    @(negedge clk);
    wrEn = 0;
    addrM[row][slot] = a;
    probM[row][slot] = p;
  endtask

  task automatic buildExp(input int row, input int mode);
    int n;
    bit emit;
    expQ.delete();
    n = (cntM[row] > 8) ? 8 : cntM[row];
    if (mode == 0) n = (cntM[row] != 0) ? 1 : 0;
    for (int i = 0; i < n; i++) begin
      if (mode == 2) begin
        emit = (probM[row][i] == 8'hFF) || (lfsrM[7:0] < probM[row][i]);
        lfsrM = {lfsrM[14:0], lfsrM[15] ^ lfsrM[13] ^ lfsrM[12] ^ lfsrM[10]};
      end else begin
        emit = 1;
      end
      if (emit) expQ.push_back(addrM[row][i]);
    end
  endtask

  // sends one event; when disturb is set, writes the table and changes
  // mode/address while the event is being processed
  task automatic sendEvent(input int row, input int mode, input string tag, input bit disturb);
    bit didDisturb = 0;
    bit clearWr = 0;
    buildExp(row, mode);
    gotQ.delete();
    @(negedge clk);
    eventOpen = 1;
    inAddr = 6'(row); modeIn = 2'(mode); inReq = 1'b1;
    while (!inAck) begin
      @(negedge clk);
      if (clearWr) begin wrEn = 0; clearWr = 0; end
      if (disturb && !didDisturb && outReq) begin
        wrEn = 1; wrIsCount = 1; wrRow = 6'(row); wrCount = 4'd0;
        modeIn = 2'd0; inAddr = 6'(row + 1);
        didDisturb = 1; clearWr = 1;
      end
    end
    wrEn = 0;
    check(gotQ.size() == expQ.size(), {tag, " output count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], {tag, " output address"}, int'(gotQ[i]), int'(expQ[i]));
    inReq = 1'b0;
    while (inAck) @(negedge clk);
    eventOpen = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 64; r++) cntM[r] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(outReq == 0, "R1 outReq after reset", int'(outReq), 0);
    check(inAck == 0, "R1 inAck after reset", int'(inAck), 0);
    check(outAddr == 0, "R1 outAddr after reset", int'(outAddr), 0);
    sendEvent(20, 1, "R1 unloaded row", 0);

    // table contents
    for (int s = 0; s < 8; s++) begin
      writeSlot(3, s, 8'(8'h30 + s), 8'hFF);
      writeSlot(9, s, 8'(8'h90 + s * 3), 8'hFF);
    end
    writeCount(3, 3);
    writeCount(9, 12);
    writeSlot(7, 0, 8'h70, 8'hFF);
    writeSlot(7, 1, 8'h71, 8'h00);
    writeSlot(7, 2, 8'h72, 8'h80);
    writeSlot(7, 3, 8'h73, 8'h40);
    writeSlot(7, 4, 8'h74, 8'hC8);
    writeSlot(7, 5, 8'h75, 8'h01);
    writeSlot(7, 6, 8'h76, 8'hFE);
    writeSlot(7, 7, 8'h77, 8'h1E);
    writeCount(7, 8);
    writeSlot(11, 0, 8'hB0, 8'hFF);
    writeSlot(11, 1, 8'hB1, 8'hFF);
    writeCount(11, 0);

    // R4 translation
    sendEvent(3, 0, "R4 translate N=3", 0);
    sendEvent(11, 0, "R4 translate N=0", 0);
    // R5 fan-out
    sendEvent(3, 1, "R5 fanout N=3", 0);
    sendEvent(9, 1, "R5 fanout N=12 clamp", 0);
    sendEvent(11, 1, "R5 fanout drop", 0);
    sendEvent(3, 3, "R5 mode 3", 0);
    // R6 probabilistic, interleaved with other modes
    for (int k = 0; k < 6; k++) begin
      sendEvent(7, 2, "R6 probabilistic", 0);
      if (k % 2 == 0) sendEvent(7, 1, "R6 no step in fan-out", 0);
    end
    sendEvent(3, 2, "R6 always-emit row", 0);
    sendEvent(11, 2, "R6 empty row", 0);
    // R7 and R8: write plus mode/address change during an event
    sendEvent(9, 1, "R8 inputs latched", 1);
    sendEvent(9, 1, "R7 busy write ignored", 0);
    // R7 idle write takes effect
    writeCount(9, 2);
    sendEvent(9, 1, "R7 idle write", 0);
    writeSlot(3, 0, 8'hEE, 8'hFF);
    sendEvent(3, 0, "R7 slot rewrite", 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule